// File: doc/BRIEF.md
# Event Routing Lookup Sequencer

This block accepts one forwarded interrupt event at a time, identified by a 32-bit source number, and walks the two routing tables that decide where the event goes. First it fetches the source's assignment entry from an external table store. That entry may be missing, invalid or masked. If it is usable, the block extracts the target queue-descriptor block, the descriptor index and the event data.

Next it fetches the queue descriptor. If the descriptor asks for it, the block hands the event data to an enqueue port and writes the updated descriptor word 1 back to the store. It then applies the descriptor-level mask and the unconditional-notify check. The outcome is one of three things: a notification toward the thread-notification stage, a silent completion, or a flagged error or unimplemented status.

Each table lookup is a request/response exchange. The request stays asserted until the store answers, so the store may take any number of cycles. Every event ends with a one-cycle completion pulse that carries a result code. The block takes no new event until that pulse has been given.

Top module: `evt_route_seq`

## Requirements
- R1: After reset `ev_ready` is 1 and every request, notify and done output is 0. Once an event is accepted (`ev_valid` and `ev_ready` both high at a clock edge), `ev_ready` stays 0 until that event's done pulse has been given.
- R2: The assignment lookup addresses block `src[31:28]` and index `src[27:0]`. The request and its address are held steady until `asn_rsp_valid`.
- R3: If the assignment response has `asn_rsp_err` set, or entry bit 63 (valid) is 0, the event ends with code 2 and no descriptor lookup is made.
- R4: If a valid assignment entry has bit 62 (mask) set, the event ends with code 1. No descriptor lookup and no notification follow.
- R5: For a usable assignment entry, the descriptor lookup addresses block `entry[59:56]` and index `entry[55:32]`. The enqueued data is `entry[30:0]`.
- R6: If the descriptor response has `dsc_rsp_err` set, or `w0[31]` (valid) is 0, the event ends with code 3 and no enqueue is made.
- R7: If `w0[30]` (enqueue) is 1, exactly one enqueue handshake takes place, carrying the data and the descriptor word 1. It is followed by exactly one write-back to the same descriptor, carrying the word 1 that the enqueue port returned. If `w0[30]` is 0, neither takes place.
- R8: If `w6[31]` (format) is 0 and `w7[7:0]` is 0xFF, the event ends with code 4, after any enqueue. With format 1, a priority of 0xFF does not mask.
- R9: If the descriptor is not masked and `w0[29]` (unconditional notify) is 0, the event ends with code 5 and no notification.
- R10: Otherwise the event ends with code 0. `ntf_valid` pulses in the same cycle as the done pulse, with `ntf_prio = w7[7:0]` and `ntf_thread = w6[15:0]`.
- R11: Each accepted event produces exactly one one-cycle `done_valid` pulse. `ev_ready` is 1 in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | Event offered |
| ev_ready | output | 1 | Block idle, event accepted when both high |
| ev_srcnum | input | 32 | Source number of the event |
| asn_req_valid | output | 1 | Assignment lookup request |
| asn_req_blk | output | 4 | Assignment table block |
| asn_req_idx | output | 28 | Assignment table index |
| asn_rsp_valid | input | 1 | Assignment response present |
| asn_rsp_err | input | 1 | Assignment lookup failed |
| asn_rsp_entry | input | 64 | Assignment entry |
| dsc_req_valid | output | 1 | Descriptor lookup request |
| dsc_req_blk | output | 4 | Descriptor block |
| dsc_req_idx | output | 24 | Descriptor index |
| dsc_rsp_valid | input | 1 | Descriptor response present |
| dsc_rsp_err | input | 1 | Descriptor lookup failed |
| dsc_rsp_w0 | input | 32 | Descriptor word 0 (control bits) |
| dsc_rsp_w1 | input | 32 | Descriptor word 1 (queue position) |
| dsc_rsp_w6 | input | 32 | Descriptor word 6 (format, thread) |
| dsc_rsp_w7 | input | 32 | Descriptor word 7 (priority) |
| enq_valid | output | 1 | Enqueue request |
| enq_blk | output | 4 | Descriptor block for the enqueue |
| enq_idx | output | 24 | Descriptor index for the enqueue |
| enq_data | output | 31 | Event data to enqueue |
| enq_word1 | output | 32 | Current descriptor word 1 |
| enq_done | input | 1 | Enqueue finished |
| enq_word1_new | input | 32 | Word 1 after the enqueue |
| wb_valid | output | 1 | Word 1 write-back request |
| wb_blk | output | 4 | Descriptor block to write |
| wb_idx | output | 24 | Descriptor index to write |
| wb_word1 | output | 32 | Word 1 value to write |
| wb_done | input | 1 | Write-back finished |
| ntf_valid | output | 1 | Notification continues |
| ntf_prio | output | 8 | Notification priority |
| ntf_thread | output | 16 | Target thread index |
| done_valid | output | 1 | Event finished pulse |
| done_code | output | 3 | Result: 0 notify, 1 source masked, 2 source error, 3 descriptor error, 4 descriptor masked, 5 unimplemented |

## Verification
The bench uses the package's default widths: a 4-bit source block field, a 4-bit descriptor block, a 24-bit descriptor index, 31 data bits and a 16-bit thread index. At these widths the all-ones source number, all-ones data and the 0xFF priority can all be driven directly, so the field-extraction boundaries are exercised. The table, enqueue and write-back responders answer in the request cycle by default. A stall control can hold back the assignment response for several cycles, which brings the hold-until-response behaviour and the busy-ready interlock within reach. Enqueued word-1 values that carry over into bit 16 and into bit 31 show that the write-back uses the value returned by the enqueue port rather than the looked-up one.

// File: rtl/evt_route_pkg.sv
package evt_route_pkg;

    // widths
    parameter int SRC_W    = 32;
    parameter int SBLK_W   = 4;
    parameter int SIDX_W   = SRC_W - SBLK_W;
    parameter int ENTRY_W  = 64;
    parameter int WORD_W   = 32;
    parameter int TBLK_W   = 4;
    parameter int TIDX_W   = 24;
    parameter int DATA_W   = 31;
    parameter int PRIO_W   = 8;
    parameter int THREAD_W = 16;

    // assignment entry layout
    parameter int A_VALID_BIT = 63;
    parameter int A_MASK_BIT  = 62;
    parameter int A_TBLK_LSB  = 56;
    parameter int A_TIDX_LSB  = 32;
    parameter int A_DATA_LSB  = 0;

    // descriptor layout
    parameter int D_VALID_BIT  = 31;  // word 0
    parameter int D_ENQ_BIT    = 30;  // word 0
    parameter int D_UCOND_BIT  = 29;  // word 0
    parameter int D_FMT_BIT    = 31;  // word 6
    parameter int D_THREAD_LSB = 0;   // word 6
    parameter int D_PRIO_LSB   = 0;   // word 7

    localparam logic [PRIO_W-1:0] PRIO_OFF = '1;

    typedef enum logic [2:0] {
        RES_NOTIFY     = 3'd0,
        RES_ASN_MASKED = 3'd1,
        RES_ASN_ERR    = 3'd2,
        RES_DSC_ERR    = 3'd3,
        RES_DSC_MASKED = 3'd4,
        RES_UNIMPL     = 3'd5
    } result_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ASN,
        ST_DSC,
        ST_ENQ,
        ST_WB,
        ST_CHECK,
        ST_DONE
    } state_e;

    typedef struct packed {
        logic              ok;
        logic              masked;
        logic [TBLK_W-1:0] tblk;
        logic [TIDX_W-1:0] tidx;
        logic [DATA_W-1:0] data;
    } asn_fields_t;

    typedef struct packed {
        logic                ok;
        logic                enq;
        logic                ucond;
        logic                fmt;
        logic [PRIO_W-1:0]   prio;
        logic [THREAD_W-1:0] thread;
    } dsc_fields_t;

    function automatic logic [SBLK_W-1:0] src_block(input logic [SRC_W-1:0] s);
        return s[SRC_W-1 -: SBLK_W];
    endfunction

    function automatic logic [SIDX_W-1:0] src_index(input logic [SRC_W-1:0] s);
        return s[SIDX_W-1:0];
    endfunction

    function automatic logic dsc_is_masked(input dsc_fields_t d);
        return (d.fmt == 1'b0) && (d.prio == PRIO_OFF);
    endfunction

endpackage

// File: rtl/evt_asn_decode.sv
module evt_asn_decode
    import evt_route_pkg::*;
(
    input  logic [ENTRY_W-1:0] entry,
    input  logic               rsp_err,
    output asn_fields_t        fields
);
    logic unused_bits;
    assign unused_bits = ^{entry[A_TBLK_LSB+TBLK_W +: (A_MASK_BIT-A_TBLK_LSB-TBLK_W)],
                           entry[A_TIDX_LSB-1 -: (A_TIDX_LSB-DATA_W)]};

    always_comb begin
        fields.ok     = !rsp_err && entry[A_VALID_BIT];
        fields.masked = entry[A_MASK_BIT];
        fields.tblk   = entry[A_TBLK_LSB +: TBLK_W];
        fields.tidx   = entry[A_TIDX_LSB +: TIDX_W];
        fields.data   = entry[A_DATA_LSB +: DATA_W];
    end
endmodule

// File: rtl/evt_dsc_decode.sv
module evt_dsc_decode
    import evt_route_pkg::*;
(
    input  logic [WORD_W-1:0] w0,
    input  logic [WORD_W-1:0] w6,
    input  logic [WORD_W-1:0] w7,
    input  logic              rsp_err,
    output dsc_fields_t       fields
);
    logic unused_bits;
    assign unused_bits = ^{w0[D_UCOND_BIT-1:0], w6[D_FMT_BIT-1:THREAD_W],
                           w7[WORD_W-1:PRIO_W]};

    always_comb begin
        fields.ok     = !rsp_err && w0[D_VALID_BIT];
        fields.enq    = w0[D_ENQ_BIT];
        fields.ucond  = w0[D_UCOND_BIT];
        fields.fmt    = w6[D_FMT_BIT];
        fields.thread = w6[D_THREAD_LSB +: THREAD_W];
        fields.prio   = w7[D_PRIO_LSB +: PRIO_W];
    end
endmodule

// File: rtl/evt_seq_ctrl.sv
module evt_seq_ctrl
    import evt_route_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        ev_valid,
    input  logic        asn_rsp_valid,
    input  asn_fields_t asn_now,
    input  logic        dsc_rsp_valid,
    input  dsc_fields_t dsc_now,
    input  dsc_fields_t dsc_held,
    input  logic        enq_done,
    input  logic        wb_done,
    output state_e      state,
    output result_e     code
);
    state_e  state_q, state_d;
    result_e code_q, code_d;

    always_comb begin
        state_d = state_q;
        code_d  = code_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ev_valid) state_d = ST_ASN;
            end
            ST_ASN: begin
                if (asn_rsp_valid) begin
                    if (!asn_now.ok) begin
                        code_d  = RES_ASN_ERR;
                        state_d = ST_DONE;
                    end else if (asn_now.masked) begin
                        code_d  = RES_ASN_MASKED;
                        state_d = ST_DONE;
                    end else begin
                        state_d = ST_DSC;
                    end
                end
            end
            ST_DSC: begin
                if (dsc_rsp_valid) begin
                    if (!dsc_now.ok) begin
                        code_d  = RES_DSC_ERR;
                        state_d = ST_DONE;
                    end else if (dsc_now.enq) begin
                        state_d = ST_ENQ;
                    end else begin
                        state_d = ST_CHECK;
                    end
                end
            end
            ST_ENQ: begin
                if (enq_done) state_d = ST_WB;
            end
            ST_WB: begin
                if (wb_done) state_d = ST_CHECK;
            end
            ST_CHECK: begin
                if (dsc_is_masked(dsc_held)) code_d = RES_DSC_MASKED;
                else if (!dsc_held.ucond)    code_d = RES_UNIMPL;
                else                         code_d = RES_NOTIFY;
                state_d = ST_DONE;
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            code_q  <= RES_NOTIFY;
        end else begin
            state_q <= state_d;
            code_q  <= code_d;
        end
    end

    assign state = state_q;
    assign code  = code_q;
endmodule

// File: rtl/evt_route_seq.sv
module evt_route_seq
    import evt_route_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                ev_valid,
    output logic                ev_ready,
    input  logic [SRC_W-1:0]    ev_srcnum,
    output logic                asn_req_valid,
    output logic [SBLK_W-1:0]   asn_req_blk,
    output logic [SIDX_W-1:0]   asn_req_idx,
    input  logic                asn_rsp_valid,
    input  logic                asn_rsp_err,
    input  logic [ENTRY_W-1:0]  asn_rsp_entry,
    output logic                dsc_req_valid,
    output logic [TBLK_W-1:0]   dsc_req_blk,
    output logic [TIDX_W-1:0]   dsc_req_idx,
    input  logic                dsc_rsp_valid,
    input  logic                dsc_rsp_err,
    input  logic [WORD_W-1:0]   dsc_rsp_w0,
    input  logic [WORD_W-1:0]   dsc_rsp_w1,
    input  logic [WORD_W-1:0]   dsc_rsp_w6,
    input  logic [WORD_W-1:0]   dsc_rsp_w7,
    output logic                enq_valid,
    output logic [TBLK_W-1:0]   enq_blk,
    output logic [TIDX_W-1:0]   enq_idx,
    output logic [DATA_W-1:0]   enq_data,
    output logic [WORD_W-1:0]   enq_word1,
    input  logic                enq_done,
    input  logic [WORD_W-1:0]   enq_word1_new,
    output logic                wb_valid,
    output logic [TBLK_W-1:0]   wb_blk,
    output logic [TIDX_W-1:0]   wb_idx,
    output logic [WORD_W-1:0]   wb_word1,
    input  logic                wb_done,
    output logic                ntf_valid,
    output logic [PRIO_W-1:0]   ntf_prio,
    output logic [THREAD_W-1:0] ntf_thread,
    output logic                done_valid,
    output logic [2:0]          done_code
);
    state_e      state;
    result_e     code;
    asn_fields_t asn_now, asn_q;
    dsc_fields_t dsc_now, dsc_q;
    logic [SRC_W-1:0]  src_q;
    logic [WORD_W-1:0] word1_q;

    evt_asn_decode u_asn_dec (
        .entry   (asn_rsp_entry),
        .rsp_err (asn_rsp_err),
        .fields  (asn_now)
    );

    evt_dsc_decode u_dsc_dec (
        .w0      (dsc_rsp_w0),
        .w6      (dsc_rsp_w6),
        .w7      (dsc_rsp_w7),
        .rsp_err (dsc_rsp_err),
        .fields  (dsc_now)
    );

    evt_seq_ctrl u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .ev_valid      (ev_valid),
        .asn_rsp_valid (asn_rsp_valid),
        .asn_now       (asn_now),
        .dsc_rsp_valid (dsc_rsp_valid),
        .dsc_now       (dsc_now),
        .dsc_held      (dsc_q),
        .enq_done      (enq_done),
        .wb_done       (wb_done),
        .state         (state),
        .code          (code)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q   <= '0;
            asn_q   <= '0;
            dsc_q   <= '0;
            word1_q <= '0;
        end else begin
            if (state == ST_IDLE && ev_valid) src_q <= ev_srcnum;
            if (state == ST_ASN && asn_rsp_valid) asn_q <= asn_now;
            if (state == ST_DSC && dsc_rsp_valid) begin
                dsc_q   <= dsc_now;
                word1_q <= dsc_rsp_w1;
            end
            if (state == ST_ENQ && enq_done) word1_q <= enq_word1_new;
        end
    end

    assign ev_ready      = (state == ST_IDLE);

    assign asn_req_valid = (state == ST_ASN);
    assign asn_req_blk   = src_block(src_q);
    assign asn_req_idx   = src_index(src_q);

    assign dsc_req_valid = (state == ST_DSC);
    assign dsc_req_blk   = asn_q.tblk;
    assign dsc_req_idx   = asn_q.tidx;

    assign enq_valid     = (state == ST_ENQ);
    assign enq_blk       = asn_q.tblk;
    assign enq_idx       = asn_q.tidx;
    assign enq_data      = asn_q.data;
    assign enq_word1     = word1_q;

    assign wb_valid      = (state == ST_WB);
    assign wb_blk        = asn_q.tblk;
    assign wb_idx        = asn_q.tidx;
    assign wb_word1      = word1_q;

    assign done_valid    = (state == ST_DONE);
    assign done_code     = code;
    assign ntf_valid     = (state == ST_DONE) && (code == RES_NOTIFY);
    assign ntf_prio      = dsc_q.prio;
    assign ntf_thread    = dsc_q.thread;
endmodule

// File: rtl/evt_route_chk.sv
module evt_route_chk
    import evt_route_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               ev_ready,
    input logic               asn_req_valid,
    input logic [SBLK_W-1:0]  asn_req_blk,
    input logic [SIDX_W-1:0]  asn_req_idx,
    input logic               asn_rsp_valid,
    input logic               asn_rsp_err,
    input logic [ENTRY_W-1:0] asn_rsp_entry,
    input logic               dsc_req_valid,
    input logic               enq_valid,
    input logic               enq_done,
    input logic               wb_valid,
    input logic               ntf_valid,
    input logic               done_valid,
    input logic [2:0]         done_code
);
    // R1
    ready_idle_chk: assert property (@(posedge clk) disable iff (rst)
        ev_ready |-> !(asn_req_valid || dsc_req_valid || enq_valid || wb_valid || done_valid));

    // R11
    one_phase_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({asn_req_valid, dsc_req_valid, enq_valid, wb_valid, done_valid}));

    // R2
    asn_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (asn_req_valid && !asn_rsp_valid) |=>
            (asn_req_valid && $stable(asn_req_blk) && $stable(asn_req_idx)));

    // R4
    asn_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (asn_req_valid && asn_rsp_valid && !asn_rsp_err &&
         asn_rsp_entry[A_VALID_BIT] && asn_rsp_entry[A_MASK_BIT]) |=>
            (done_valid && done_code == RES_ASN_MASKED));

    // R7
    enq_wb_chk: assert property (@(posedge clk) disable iff (rst)
        (enq_valid && enq_done) |=> wb_valid);

    // R10
    ntf_done_chk: assert property (@(posedge clk) disable iff (rst)
        ntf_valid |-> (done_valid && done_code == RES_NOTIFY));

    // R11
    done_ret_chk: assert property (@(posedge clk) disable iff (rst)
        done_valid |=> (ev_ready && !done_valid));
endmodule

bind evt_route_seq evt_route_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .ev_ready      (ev_ready),
    .asn_req_valid (asn_req_valid),
    .asn_req_blk   (asn_req_blk),
    .asn_req_idx   (asn_req_idx),
    .asn_rsp_valid (asn_rsp_valid),
    .asn_rsp_err   (asn_rsp_err),
    .asn_rsp_entry (asn_rsp_entry),
    .dsc_req_valid (dsc_req_valid),
    .enq_valid     (enq_valid),
    .enq_done      (enq_done),
    .wb_valid      (wb_valid),
    .ntf_valid     (ntf_valid),
    .done_valid    (done_valid),
    .done_code     (done_code)
);

// File: tb/evt_route_seq_bench.sv
`timescale 1ns/1ps
module evt_route_seq_bench;
    typedef struct packed {
        logic [31:0] src;
        logic [63:0] entry;
        logic        aerr;
        logic [31:0] w0;
        logic [31:0] w1;
        logic [31:0] w6;
        logic [31:0] w7;
        logic        derr;
        logic [2:0]  code;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{32'h3000_0012, 64'h85000ABC_12345678, 1'b0, 32'hE000_0000, 32'h0000_0010, 32'h0000_0042, 32'h0000_0005, 1'b0, 3'd0},
        '{32'hF0FF_FFFF, 64'h8A123456_7FFFFFFF, 1'b1, 32'hE000_0000, 32'h0000_0010, 32'h0000_0042, 32'h0000_0005, 1'b0, 3'd2},
        '{32'h1000_0001, 64'h05000ABC_12345678, 1'b0, 32'hE000_0000, 32'h0000_0010, 32'h0000_0042, 32'h0000_0005, 1'b0, 3'd2},
        '{32'h2ABC_DEF0, 64'hC5000ABC_12345678, 1'b0, 32'hE000_0000, 32'h0000_0010, 32'h0000_0042, 32'h0000_0005, 1'b0, 3'd1},
        '{32'h4000_0004, 64'h85000ABC_12345678, 1'b0, 32'hE000_0000, 32'h0000_0010, 32'h0000_0042, 32'h0000_0005, 1'b1, 3'd3},
        '{32'h5000_0005, 64'h8A123456_7FFFFFFF, 1'b0, 32'h6000_0000, 32'h0000_0010, 32'h0000_0042, 32'h0000_0005, 1'b0, 3'd3},
        '{32'h6000_0006, 64'h85000ABC_12345678, 1'b0, 32'hE000_0000, 32'h0000_FFFF, 32'h0000_0001, 32'h0000_00FF, 1'b0, 3'd4},
        '{32'h7000_0007, 64'h8A123456_7FFFFFFF, 1'b0, 32'hA000_0000, 32'h0000_0000, 32'h8000_1234, 32'h0000_00FF, 1'b0, 3'd0},
        '{32'h8000_0008, 64'h85000ABC_12345678, 1'b0, 32'h8000_0000, 32'h0000_0000, 32'h0000_0003, 32'h0000_0007, 1'b0, 3'd5},
        '{32'h0FFF_FFFF, 64'h8A123456_7FFFFFFF, 1'b0, 32'hC000_0000, 32'h7FFF_FFFF, 32'h0000_0000, 32'h0000_0010, 1'b0, 3'd5},
        '{32'h9000_0009, 64'h85000ABC_12345678, 1'b0, 32'hA000_0000, 32'h0000_0000, 32'h0000_BEEF, 32'h0000_00FE, 1'b0, 3'd0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ev_valid = 1'b0;
    logic [31:0] ev_srcnum = '0;
    logic        stall = 1'b0;
    vec_t        cur = '0;

    logic        ev_ready;
    logic        asn_req_valid;
    logic [3:0]  asn_req_blk;
    logic [27:0] asn_req_idx;
    logic        asn_rsp_valid;
    logic        dsc_req_valid;
    logic [3:0]  dsc_req_blk;
    logic [23:0] dsc_req_idx;
    logic        dsc_rsp_valid;
    logic        enq_valid;
    logic [3:0]  enq_blk;
    logic [23:0] enq_idx;
    logic [30:0] enq_data;
    logic [31:0] enq_word1;
    logic        enq_done;
    logic [31:0] enq_word1_new;
    logic        wb_valid;
    logic [3:0]  wb_blk;
    logic [23:0] wb_idx;
    logic [31:0] wb_word1;
    logic        wb_done;
    logic        ntf_valid;
    logic [7:0]  ntf_prio;
    logic [15:0] ntf_thread;
    logic        done_valid;
    logic [2:0]  done_code;

    assign asn_rsp_valid = asn_req_valid && !stall;
    assign dsc_rsp_valid = dsc_req_valid;
    assign enq_done      = enq_valid;
    assign enq_word1_new = enq_word1 + 32'd1;
    assign wb_done       = wb_valid;

    always #2.5 clk = ~clk;

    evt_route_seq u_evt_route_seq (
        .clk(clk), .rst(rst),
        .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_srcnum(ev_srcnum),
        .asn_req_valid(asn_req_valid), .asn_req_blk(asn_req_blk), .asn_req_idx(asn_req_idx),
        .asn_rsp_valid(asn_rsp_valid), .asn_rsp_err(cur.aerr), .asn_rsp_entry(cur.entry),
        .dsc_req_valid(dsc_req_valid), .dsc_req_blk(dsc_req_blk), .dsc_req_idx(dsc_req_idx),
        .dsc_rsp_valid(dsc_rsp_valid), .dsc_rsp_err(cur.derr),
        .dsc_rsp_w0(cur.w0), .dsc_rsp_w1(cur.w1), .dsc_rsp_w6(cur.w6), .dsc_rsp_w7(cur.w7),
        .enq_valid(enq_valid), .enq_blk(enq_blk), .enq_idx(enq_idx), .enq_data(enq_data),
        .enq_word1(enq_word1), .enq_done(enq_done), .enq_word1_new(enq_word1_new),
        .wb_valid(wb_valid), .wb_blk(wb_blk), .wb_idx(wb_idx), .wb_word1(wb_word1), .wb_done(wb_done),
        .ntf_valid(ntf_valid), .ntf_prio(ntf_prio), .ntf_thread(ntf_thread),
        .done_valid(done_valid), .done_code(done_code)
    );

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic string code_tag(input logic [2:0] c);
        case (c)
            3'd0: return "R10 code";
            3'd1: return "R4 code";
            3'd2: return "R3 code";
            3'd3: return "R6 code";
            3'd4: return "R8 code";
            default: return "R9 code";
        endcase
    endfunction

    task automatic run_vec(input vec_t v, input int stall_n);
        int   n_asn = 0, n_dsc = 0, n_enq = 0, n_wb = 0, n_done = 0;
        bit   busy_ready = 0, blk_moved = 0, seen_ntf = 0;
        logic [3:0]  a_blk = '0;  logic [27:0] a_idx = '0;
        logic [3:0]  d_blk = '0;  logic [23:0] d_idx = '0;
        logic [30:0] e_data = '0; logic [31:0] e_w1 = '0;
        logic [3:0]  e_blk = '0;  logic [23:0] e_idx = '0;
        logic [3:0]  w_blk = '0;  logic [23:0] w_idx = '0; logic [31:0] w_w1 = '0;
        logic [2:0]  got_code = '0;
        logic [7:0]  got_prio = '0; logic [15:0] got_thr = '0;
        bit a_ok, go_dsc, d_ok, go_enq;
        a_ok   = !v.aerr && v.entry[63];
        go_dsc = a_ok && !v.entry[62];
        d_ok   = !v.derr && v.w0[31];
        go_enq = go_dsc && d_ok && v.w0[30];

        cur = v;
        stall = (stall_n > 0);
        ev_valid = 1'b1;
        ev_srcnum = v.src;
        @(negedge clk);
        ev_valid = 1'b0;
        for (int c = 0; c < 200; c++) begin
            if (ev_ready) busy_ready = 1;
            if (asn_req_valid) begin
                if (n_asn > 0 && (asn_req_blk != a_blk || asn_req_idx != a_idx)) blk_moved = 1;
                a_blk = asn_req_blk; a_idx = asn_req_idx; n_asn++;
            end
            if (dsc_req_valid) begin n_dsc++; d_blk = dsc_req_blk; d_idx = dsc_req_idx; end
            if (enq_valid) begin
                n_enq++; e_data = enq_data; e_w1 = enq_word1; e_blk = enq_blk; e_idx = enq_idx;
            end
            if (wb_valid) begin n_wb++; w_blk = wb_blk; w_idx = wb_idx; w_w1 = wb_word1; end
            if (ntf_valid) begin seen_ntf = 1; got_prio = ntf_prio; got_thr = ntf_thread; end
            if (done_valid) begin n_done++; got_code = done_code; break; end
            if (stall_n > 0) begin
                stall_n--;
                if (stall_n == 0) stall = 1'b0;
            end
            @(negedge clk);
        end
        chk("R11 done pulse", 64'(n_done), 64'd1);
        chk(code_tag(v.code), 64'(got_code), 64'(v.code));
        chk("R1 busy ready low", 64'(busy_ready), 64'd0);
        chk("R2 asn blk", 64'(a_blk), 64'(v.src[31:28]));
        chk("R2 asn idx", 64'(a_idx), 64'(v.src[27:0]));
        chk("R2 asn hold", 64'(blk_moved), 64'd0);
        chk("R3 R4 dsc lookup made", 64'(n_dsc > 0), 64'(go_dsc));
        if (go_dsc) begin
            chk("R5 dsc blk", 64'(d_blk), 64'(v.entry[59:56]));
            chk("R5 dsc idx", 64'(d_idx), 64'(v.entry[55:32]));
        end
        chk("R7 enq count", 64'(n_enq), go_enq ? 64'd1 : 64'd0);
        chk("R7 wb count", 64'(n_wb), go_enq ? 64'd1 : 64'd0);
        if (go_enq) begin
            chk("R5 enq data", 64'(e_data), 64'(v.entry[30:0]));
            chk("R7 enq word1", 64'(e_w1), 64'(v.w1));
            chk("R7 enq target", 64'({e_blk, e_idx}), 64'({v.entry[59:56], v.entry[55:32]}));
            chk("R7 wb word1", 64'(w_w1), 64'(v.w1 + 32'd1));
            chk("R7 wb target", 64'({w_blk, w_idx}), 64'({v.entry[59:56], v.entry[55:32]}));
        end
        chk("R10 notify seen", 64'(seen_ntf), 64'(v.code == 3'd0));
        if (v.code == 3'd0) begin
            chk("R10 prio", 64'(got_prio), 64'(v.w7[7:0]));
            chk("R10 thread", 64'(got_thr), 64'(v.w6[15:0]));
        end
        @(negedge clk);
        chk("R11 ready after done", 64'(ev_ready), 64'd1);
        chk("R11 single pulse", 64'(done_valid), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 ready at reset", 64'(ev_ready), 64'd1);
        chk("R1 outputs quiet", 64'({asn_req_valid, dsc_req_valid, enq_valid, wb_valid,
                                     ntf_valid, done_valid}), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 idle after reset", 64'({ev_ready, done_valid}), 64'b10);

        for (int i = 0; i < NV; i++) run_vec(VECS[i], 0);

        // R2 held request while the table store stalls
        run_vec(VECS[0], 6);
        run_vec(VECS[7], 3);

        // R1 reset in the middle of an event returns to idle
        cur = VECS[0];
        stall = 1'b1;
        ev_valid = 1'b1; ev_srcnum = VECS[0].src;
        @(negedge clk);
        ev_valid = 1'b0;
        chk("R1 busy after accept", 64'(ev_ready), 64'd0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0; stall = 1'b0;
        chk("R1 ready after mid reset", 64'({ev_ready, asn_req_valid}), 64'b10);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule